// File: doc/BRIEF.md
# Compressed ALU Instruction Expander

This block turns a 16-bit compressed RISC-V instruction into the 32-bit base instruction that does the same work. It covers a small arithmetic group: the three shift-immediate forms (left, logical right, arithmetic right), AND with an immediate, and the register-register subtract and exclusive-or. Every other 16-bit encoding is flagged illegal and gives an all-zero word. The block sits in a fetch or decode path. A 16-bit word is presented with a valid strobe, and the expanded word, an illegal flag and an output valid appear one clock later.

The decode is written as a small set of named operation classes: `OPK_BAD`, `OPK_SRLI`, `OPK_SRAI`, `OPK_SLLI`, `OPK_ANDI`, `OPK_SUB` and `OPK_XOR`. A classifier picks one class from the quadrant and function bits. A shift-amount unit builds the amount and checks whether it is in range. An assembler packs the 32-bit fields for the chosen class, and a single register stage at the top holds the result. The data width `XLEN` is a parameter (32 or 64) and only changes which shift amounts are legal.

The shift-amount rule needs care. A 6-bit field of zero does not mean "no shift". It stands for a shift of 64. Any amount that reaches XLEN or more is rejected, so a zero field is illegal at both widths, and a set top amount bit is illegal at width 32.

Top module: `cx_alu_expand`

## Requirements
- R1: With input bits [1:0]=01 and [15:13]=100, bits [11:10]=00 expand to `{6'b000000, sh[5:0], rs, 3'b101, rs, 7'b0010011}` and bits [11:10]=01 expand to the same word with bits [31:26]=6'b010000 (instruction bit 30 set).
- R2: With input bits [1:0]=10 and [15:13]=000, the word expands to `{6'b000000, sh[5:0], r, 3'b001, r, 7'b0010011}`, where r = input bits [11:7] is both source and destination.
- R3: In the forms selected by bits [1:0]=01, a 3-bit register field f names register 8+f (encoded `{2'b01, f}`). The field at [9:7] is destination and first source, and for SUB/XOR the field at [4:2] is the second source.
- R4: The shift amount sh is `{bit 12, bits [6:2]}`. When that 6-bit value is zero it is treated as 64 and the word is illegal at both widths.
- R5: A shift amount of XLEN or more is illegal. At XLEN=32 this means any shift with bit 12 set; at XLEN=64 every nonzero amount is legal.
- R6: Bits [11:10]=10 in the R1 group expand to AND-immediate `{imm12, rs, 3'b111, rs, 7'b0010011}`, where imm12 is `{bit 12, bits [6:2]}` sign-extended from bit 12.
- R7: Bits [11:10]=11 with bit 12=0 in the R1 group select SUB when bits [6:5]=00 (`{7'b0100000, rs2, rs, 3'b000, rs, 7'b0110011}`) and XOR when bits [6:5]=01 (`{7'b0000000, rs2, rs, 3'b100, rs, 7'b0110011}`).
- R8: Every other input is illegal: bits [1:0]=11, quadrant 00, other function codes, bit 12=1 in the register-register group, and bits [6:5] of 10 or 11. An illegal result sets the flag and drives an all-zero word.
- R9: Outputs are registered. Output valid equals input valid from the previous clock, and a synchronous reset clears output valid, the word and the flag.
- R10: When input valid is low, the word and the illegal flag keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Input word is valid this cycle |
| in_word_i | input | 16 | Compressed instruction |
| out_valid_o | output | 1 | Registered result is valid |
| out_word_o | output | 32 | Expanded 32-bit instruction, zero when illegal |
| out_illegal_o | output | 1 | Input was not a supported legal encoding |

## Verification
The bench builds two copies of the block and drives both with the same stimulus: one with XLEN=64 and one with XLEN=32. Used side by side, they show the full range check. An amount of 32 to 63 is accepted at one width and refused at the other, and an encoded zero is refused at both. That makes the zero-means-64 substitution visible at 64, where a plain range check would have let it through.

// File: rtl/cx_pkg.sv
package cx_pkg;

    typedef enum logic [2:0] {
        OPK_BAD  = 3'd0,
        OPK_SRLI = 3'd1,
        OPK_SRAI = 3'd2,
        OPK_SLLI = 3'd3,
        OPK_ANDI = 3'd4,
        OPK_SUB  = 3'd5,
        OPK_XOR  = 3'd6
    } cx_op_e;

    localparam logic [6:0] OPC_IMM = 7'b0010011;
    localparam logic [6:0] OPC_REG = 7'b0110011;

    localparam logic [2:0] F3_SR   = 3'b101;
    localparam logic [2:0] F3_SL   = 3'b001;
    localparam logic [2:0] F3_AND  = 3'b111;
    localparam logic [2:0] F3_SUB  = 3'b000;
    localparam logic [2:0] F3_XOR  = 3'b100;

    localparam logic [1:0] QD_ONE  = 2'b01;
    localparam logic [1:0] QD_TWO  = 2'b10;

    // compact register field -> architectural register 8..15
    function automatic logic [4:0] prime_reg(input logic [2:0] f);
        return {2'b01, f};
    endfunction

endpackage

// File: rtl/cx_classify.sv
module cx_classify
    import cx_pkg::*;
(
    input  logic [1:0] quad_i,
    input  logic [2:0] funct3_i,
    input  logic       b12_i,
    input  logic [1:0] sel_i,
    input  logic [1:0] sub_i,
    output cx_op_e     op_o
);

    always_comb begin
        op_o = OPK_BAD;
        unique case (quad_i)
            QD_ONE: begin
                if (funct3_i == 3'b100) begin
                    unique case (sel_i)
                        2'b00: op_o = OPK_SRLI;
                        2'b01: op_o = OPK_SRAI;
                        2'b10: op_o = OPK_ANDI;
                        2'b11: begin
                            if (!b12_i) begin
                                unique case (sub_i)
                                    2'b00:   op_o = OPK_SUB;
                                    2'b01:   op_o = OPK_XOR;
                                    default: op_o = OPK_BAD;
                                endcase
                            end
                        end
                        default: op_o = OPK_BAD;
                    endcase
                end
            end
            QD_TWO: begin
                if (funct3_i == 3'b000) begin
                    op_o = OPK_SLLI;
                end
            end
            default: op_o = OPK_BAD;
        endcase
    end

endmodule

// File: rtl/cx_shamt.sv
module cx_shamt #(
    parameter int XLEN = 64
) (
    input  logic       b12_i,
    input  logic [4:0] low_i,
    output logic [5:0] amount_o,
    output logic       in_range_o
);

    localparam int AW = 7;
    localparam logic [AW-1:0] LIMIT    = AW'(XLEN);
    localparam logic [AW-1:0] ZERO_SUB = AW'(64);

    logic [5:0]    raw;
    logic [AW-1:0] eff;

    always_comb begin
        raw = {b12_i, low_i};
        eff = (raw == 6'd0) ? ZERO_SUB : {1'b0, raw};
        amount_o = eff[5:0];
    end

    generate
        if (XLEN == 32) begin : g_narrow
            always_comb in_range_o = (eff < LIMIT);
        end else begin : g_wide
            always_comb in_range_o = (eff < LIMIT) && (eff != ZERO_SUB);
        end
    endgenerate

endmodule

// File: rtl/cx_assemble.sv
module cx_assemble
    import cx_pkg::*;
(
    input  cx_op_e      op_i,
    input  logic        b12_i,
    input  logic [4:0]  rfull_i,
    input  logic [4:0]  low_i,
    input  logic [5:0]  amount_i,
    input  logic        sh_ok_i,
    output logic [31:0] word_o,
    output logic        illegal_o
);

    logic [4:0]  rp1;
    logic [4:0]  rp2;
    logic [11:0] imm12;

    always_comb begin
        rp1   = prime_reg(rfull_i[2:0]);
        rp2   = prime_reg(low_i[2:0]);
        imm12 = {{6{b12_i}}, b12_i, low_i};
    end

    always_comb begin
        word_o    = 32'd0;
        illegal_o = 1'b0;
        unique case (op_i)
            OPK_SRLI: begin
                if (sh_ok_i) word_o = {6'b000000, amount_i, rp1, F3_SR, rp1, OPC_IMM};
                else         illegal_o = 1'b1;
            end
            OPK_SRAI: begin
                if (sh_ok_i) word_o = {6'b010000, amount_i, rp1, F3_SR, rp1, OPC_IMM};
                else         illegal_o = 1'b1;
            end
            OPK_SLLI: begin
                if (sh_ok_i) word_o = {6'b000000, amount_i, rfull_i, F3_SL, rfull_i, OPC_IMM};
                else         illegal_o = 1'b1;
            end
            OPK_ANDI: word_o = {imm12, rp1, F3_AND, rp1, OPC_IMM};
            OPK_SUB:  word_o = {7'b0100000, rp2, rp1, F3_SUB, rp1, OPC_REG};
            OPK_XOR:  word_o = {7'b0000000, rp2, rp1, F3_XOR, rp1, OPC_REG};
            default:  illegal_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/cx_alu_expand.sv
module cx_alu_expand
    import cx_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        in_valid_i,
    input  logic [15:0] in_word_i,
    output logic        out_valid_o,
    output logic [31:0] out_word_o,
    output logic        out_illegal_o
);

    cx_op_e      op;
    logic [5:0]  sh_amount;
    logic        sh_ok;
    logic [31:0] word_c;
    logic        ill_c;

    cx_classify u_classify (
        .quad_i   (in_word_i[1:0]),
        .funct3_i (in_word_i[15:13]),
        .b12_i    (in_word_i[12]),
        .sel_i    (in_word_i[11:10]),
        .sub_i    (in_word_i[6:5]),
        .op_o     (op)
    );

    cx_shamt #(.XLEN(XLEN)) u_shamt (
        .b12_i      (in_word_i[12]),
        .low_i      (in_word_i[6:2]),
        .amount_o   (sh_amount),
        .in_range_o (sh_ok)
    );

    cx_assemble u_assemble (
        .op_i      (op),
        .b12_i     (in_word_i[12]),
        .rfull_i   (in_word_i[11:7]),
        .low_i     (in_word_i[6:2]),
        .amount_i  (sh_amount),
        .sh_ok_i   (sh_ok),
        .word_o    (word_c),
        .illegal_o (ill_c)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_valid_o <= 1'b0;
        end else begin
            out_valid_o <= in_valid_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_word_o    <= 32'd0;
            out_illegal_o <= 1'b0;
        end else if (in_valid_i) begin
            out_word_o    <= word_c;
            out_illegal_o <= ill_c;
        end
    end

    logic is_shift;
    always_comb is_shift = (op == OPK_SRLI) || (op == OPK_SRAI) || (op == OPK_SLLI);

    AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (rst_i)
        in_valid_i |=> out_valid_o); // R9
    AST_VALID_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
        !in_valid_i |=> !out_valid_o); // R9
    AST_HOLD_DATA: assert property (@(posedge clk_i) disable iff (rst_i)
        !in_valid_i |=> ($stable(out_word_o) && $stable(out_illegal_o))); // R10
    AST_ILLEGAL_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        out_illegal_o |-> (out_word_o == 32'd0)); // R8
    AST_LOW_ELEVEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && in_word_i[1:0] == 2'b11) |=> out_illegal_o); // R8
    AST_ZERO_SHIFT: assert property (@(posedge clk_i) disable iff (rst_i)
        (in_valid_i && is_shift && in_word_i[12] == 1'b0 && in_word_i[6:2] == 5'd0)
        |=> out_illegal_o); // R4
    AST_NARROW_RANGE: assert property (@(posedge clk_i) disable iff (rst_i)
        (XLEN == 32 && in_valid_i && is_shift && in_word_i[12]) |=> out_illegal_o); // R5
    AST_LEGAL_OPCODE: assert property (@(posedge clk_i) disable iff (rst_i)
        (out_valid_o && !out_illegal_o) |-> (out_word_o[1:0] == 2'b11)); // R8

endmodule

// File: tb/cx_alu_expand_tb.sv
module cx_alu_expand_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [15:0] in_word;
    logic        v64, i64, v32, i32;
    logic [31:0] w64, w32;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 0;

    always #2.5 clk = ~clk;

    cx_alu_expand #(.XLEN(64)) dut_i (
        .clk_i(clk), .rst_i(rst), .in_valid_i(in_valid), .in_word_i(in_word),
        .out_valid_o(v64), .out_word_o(w64), .out_illegal_o(i64));

    cx_alu_expand #(.XLEN(32)) dut32_i (
        .clk_i(clk), .rst_i(rst), .in_valid_i(in_valid), .in_word_i(in_word),
        .out_valid_o(v32), .out_word_o(w32), .out_illegal_o(i32));

    function automatic logic [15:0] q1(input logic [1:0] f2, input logic b12,
                                       input logic [2:0] r, input logic [4:0] lo);
        return {3'b100, b12, f2, r, lo, 2'b01};
    endfunction

    function automatic logic [15:0] q2(input logic b12, input logic [4:0] r,
                                       input logic [4:0] lo);
        return {3'b000, b12, r, lo, 2'b10};
    endfunction

    // expected legal word derived from field layouts in R1, R2, R3, R6, R7
    function automatic logic [31:0] model(input logic [15:0] c);
        logic [4:0] d, s2;
        logic [5:0] sh;
        d  = {2'b01, c[9:7]};
        s2 = {2'b01, c[4:2]};
        sh = {c[12], c[6:2]};
        if (c[1:0] == 2'b10) return {6'd0, sh, c[11:7], 3'b001, c[11:7], 7'h13};
        case (c[11:10])
            2'b00:   return {6'd0, sh, d, 3'b101, d, 7'h13};
            2'b01:   return {6'b010000, sh, d, 3'b101, d, 7'h13};
            2'b10:   return {{7{c[12]}}, c[6:2], d, 3'b111, d, 7'h13};
            default: return (c[5]) ? {7'd0, s2, d, 3'b100, d, 7'h33}
                                   : {7'b0100000, s2, d, 3'b000, d, 7'h33};
        endcase
    endfunction

    typedef struct packed {
        logic [15:0] insn;
        logic        ill64;
        logic        ill32;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{q1(2'b00, 1'b0, 3'd3, 5'd5),  1'b0, 1'b0, 4'd1},  // R1 srli
        '{q1(2'b00, 1'b1, 3'd0, 5'd0),  1'b0, 1'b1, 4'd5},  // R5 amount 32
        '{q1(2'b00, 1'b0, 3'd2, 5'd0),  1'b1, 1'b1, 4'd4},  // R4 zero
        '{q1(2'b01, 1'b0, 3'd7, 5'd31), 1'b0, 1'b0, 4'd1},  // R1 srai
        '{q1(2'b01, 1'b1, 3'd1, 5'd31), 1'b0, 1'b1, 4'd5},  // R5 amount 63
        '{q1(2'b10, 1'b1, 3'd4, 5'b10110), 1'b0, 1'b0, 4'd6}, // R6 negative imm
        '{q1(2'b10, 1'b0, 3'd6, 5'd0),  1'b0, 1'b0, 4'd6},  // R6 zero imm
        '{q1(2'b11, 1'b0, 3'd1, 5'b00101), 1'b0, 1'b0, 4'd7}, // R7 sub
        '{q1(2'b11, 1'b0, 3'd5, 5'b01010), 1'b0, 1'b0, 4'd7}, // R7 xor
        '{q1(2'b11, 1'b0, 3'd2, 5'b10011), 1'b1, 1'b1, 4'd8}, // R8 sel 10
        '{q1(2'b11, 1'b1, 3'd2, 5'b00011), 1'b1, 1'b1, 4'd8}, // R8 b12 set
        '{q2(1'b0, 5'd31, 5'd4),        1'b0, 1'b0, 4'd2},  // R2 slli
        '{q2(1'b1, 5'd9, 5'd1),         1'b0, 1'b1, 4'd5},  // R5 amount 33
        '{q2(1'b0, 5'd10, 5'd0),        1'b1, 1'b1, 4'd4},  // R4 slli zero
        '{16'h8007,                     1'b1, 1'b1, 4'd8},  // R8 low bits 11
        '{16'h4000,                     1'b1, 1'b1, 4'd8},  // R8 quadrant 00
        '{16'h0505,                     1'b1, 1'b1, 4'd8}   // R8 other funct3
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string rname(input logic [3:0] n);
        case (n)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic apply(input logic v, input logic [15:0] w);
        @(negedge clk);
        in_valid = v;
        in_word  = w;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] keep;
        rst = 1'b1; in_valid = 1'b0; in_word = 16'd0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9", {31'd0, v64}, 32'd0);
        chk("R9", w64, 32'd0);
        chk("R9", {31'd0, i32}, 32'd0);
        rst = 1'b0;

        foreach (VEC[k]) begin
            apply(1'b1, VEC[k].insn);
            chk("R9", {30'd0, v64, v32}, 32'd3);
            chk(rname(VEC[k].req), {31'd0, i64}, {31'd0, VEC[k].ill64});
            chk(rname(VEC[k].req), {31'd0, i32}, {31'd0, VEC[k].ill32});
            chk(rname(VEC[k].req), w64, VEC[k].ill64 ? 32'd0 : model(VEC[k].insn));
            chk(rname(VEC[k].req), w32, VEC[k].ill32 ? 32'd0 : model(VEC[k].insn));
        end

        // R1 R3 hand-checked: shift right logical of x8 by 1
        apply(1'b1, 16'h8005);
        chk("R3", w64, 32'h00145413);

        // R10 hold when input valid is low
        keep = w64;
        apply(1'b0, 16'h4000);
        chk("R9", {31'd0, v64}, 32'd0);
        chk("R10", w64, keep);
        chk("R10", {31'd0, i64}, 32'd0);

        // R9 reset clears valid even with input valid high
        @(negedge clk);
        in_valid = 1'b1; in_word = 16'h8005; rst = 1'b1;
        @(negedge clk);
        chk("R9", {30'd0, v64, v32}, 32'd0);
        chk("R9", w32, 32'd0);
        rst = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        finish_run();
    end

endmodule